// File: doc/BRIEF.md
# Per-Hart Translation Cache with Filtered Fence Invalidation

This block is a small, fully associative cache of address translations for one hardware thread. A lookup presents a virtual page number and an address-space identifier (ASID). One cycle later the block returns a hit flag and the matching physical page number. Entries are loaded from an external page-table walker through a refill port. The slot to overwrite is picked round-robin.

A fence command removes stale translations after page tables change. It carries a full virtual address and an ASID. Each operand has an "all" qualifier that stands for a zero register selector, so the command can clear everything, one page, one address space, or one page within one address space. The command is privileged. Issued from user mode, it changes nothing and raises an illegal-instruction fault. The fence acts on this cache alone and produces no request toward other threads or toward instruction or data caches.

Top module: `xlat_cache`

## Requirements
- R1: After reset every entry is invalid, `lk_hit` and `lk_ppn` read zero, and `fc_illegal` is low.
- R2: A lookup with `lk_req` high returns `lk_hit`=1 in the next cycle when a valid entry has an equal VPN and is either global or has an equal ASID, with `lk_ppn` equal to that entry's PPN. On a miss, or without a request, `lk_hit` and `lk_ppn` read zero.
- R3: Each refill writes the slot under a round-robin pointer that starts at slot 0 and wraps after the last slot. With 8 slots, the ninth refill displaces the first refilled entry and leaves the others in place.
- R4: A permitted fence with both "all" qualifiers set invalidates every entry, global ones included.
- R5: A permitted fence with only the ASID qualifier set to "all" invalidates every entry whose VPN equals `fc_va[VA_W-1:12]`, whatever its ASID and global bit. The low 12 offset bits of `fc_va` are ignored.
- R6: A permitted fence with only the address qualifier set to "all" invalidates the non-global entries whose ASID equals `fc_asid`. Global entries survive.
- R7: A permitted fence with neither qualifier set invalidates only non-global entries that match both VPN and ASID.
- R8: `priv` encodes 2'b00 user, 2'b01 supervisor, 2'b11 machine; 2'b10 is reserved and is treated like user. A fence in user or reserved mode changes no entry and raises `fc_illegal` for exactly the next cycle. A fence in supervisor or machine mode never raises it.
- R9: A fence takes effect in one cycle. A lookup issued in the cycle after the fence misses on every entry the fence removed.
- R10: When a refill and a permitted fence arrive in the same cycle, the refill is written first and the fence filter is then applied. A refilled entry that matches the filter is invalid afterwards. One that does not match stays valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_req | input | 1 | Lookup request |
| lk_vpn | input | VA_W-PG_OFF | Lookup virtual page number |
| lk_asid | input | ASID_W | Lookup address-space identifier |
| lk_hit | output | 1 | Lookup hit, one cycle after request |
| lk_ppn | output | PPN_W | Physical page number of the hit, zero on miss |
| fill_en | input | 1 | Refill strobe from the walker |
| fill_vpn | input | VA_W-PG_OFF | Refill virtual page number |
| fill_asid | input | ASID_W | Refill ASID |
| fill_ppn | input | PPN_W | Refill physical page number |
| fill_glb | input | 1 | Refill entry is global |
| fc_req | input | 1 | Fence command strobe |
| fc_va | input | VA_W | Fence virtual-address operand |
| fc_va_all | input | 1 | Address selector is zero: all addresses |
| fc_asid | input | ASID_W | Fence ASID operand |
| fc_asid_all | input | 1 | ASID selector is zero: all address spaces |
| priv | input | 2 | Current privilege level |
| fc_illegal | output | 1 | Illegal-instruction fault for a fence, one cycle after it |

## Verification
On every cycle the assertions check the privilege rules of the fence: a user or reserved-mode fence faults and leaves the valid bits unchanged, and a fence with both qualifiers set to "all" leaves no valid entry. They also check that at most one slot hits, that no request means no hit, and that every slot a fence marks for removal is invalid in the next cycle, refill or not. Which entries each filter form removes or spares, global-entry survival, offset-bit blindness, round-robin placement and the returned physical page numbers are shown only by the bench's scenarios. Those scenarios fill known contents and then probe them with lookups.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

  typedef enum logic [1:0] {
    PRIV_U   = 2'b00,
    PRIV_S   = 2'b01,
    PRIV_RSV = 2'b10,
    PRIV_M   = 2'b11
  } priv_e;

  localparam int unsigned DEF_ENTRIES = 8;
  localparam int unsigned DEF_VA_W    = 39;
  localparam int unsigned DEF_PG_OFF  = 12;
  localparam int unsigned DEF_ASID_W  = 9;
  localparam int unsigned DEF_PPN_W   = 20;

  // A fence may execute only from supervisor or machine level.
  function automatic logic fence_permitted(input priv_e p);
    return (p == PRIV_S) || (p == PRIV_M);
  endfunction

endpackage

// File: rtl/xlat_rr_ptr.sv
module xlat_rr_ptr #(
  parameter int unsigned N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv,
  output logic [N-1:0] sel
);
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1;

  logic [IW-1:0] ptr_q;

  always_ff @(posedge clk) begin
    if (!rst_n)
      ptr_q <= '0;
    else if (adv)
      ptr_q <= (ptr_q == IW'(N - 1)) ? '0 : ptr_q + 1'b1;
  end

  for (genvar i = 0; i < N; i++) begin : g_sel
    assign sel[i] = (ptr_q == IW'(i));
  end

endmodule

// File: rtl/xlat_slot.sv
module xlat_slot #(
  parameter int unsigned VPN_W  = 27,
  parameter int unsigned ASID_W = 9,
  parameter int unsigned PPN_W  = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [VPN_W-1:0]  wr_vpn,
  input  logic [ASID_W-1:0] wr_asid,
  input  logic [PPN_W-1:0]  wr_ppn,
  input  logic              wr_glb,
  input  logic              fc_go,
  input  logic [VPN_W-1:0]  fc_vpn,
  input  logic              fc_va_all,
  input  logic [ASID_W-1:0] fc_asid,
  input  logic              fc_asid_all,
  input  logic [VPN_W-1:0]  lk_vpn,
  input  logic [ASID_W-1:0] lk_asid,
  output logic              hit,
  output logic [PPN_W-1:0]  ppn,
  output logic              valid_o,
  output logic              kill_o
);

  // Translation match: page equal and either global or same address space.
  function automatic logic lookup_match(
    input logic v, input logic g, input logic [ASID_W-1:0] a, input logic [VPN_W-1:0] pg,
    input logic [VPN_W-1:0] q_pg, input logic [ASID_W-1:0] q_a);
    return v && (pg == q_pg) && (g || (a == q_a));
  endfunction

  // Fence filter: an ASID filter spares global entries.
  function automatic logic fence_match(
    input logic v, input logic g, input logic [ASID_W-1:0] a, input logic [VPN_W-1:0] pg,
    input logic [VPN_W-1:0] f_pg, input logic f_pg_all,
    input logic [ASID_W-1:0] f_a, input logic f_a_all);
    return v && (f_pg_all || (pg == f_pg)) && (f_a_all || (!g && (a == f_a)));
  endfunction

  logic              v_q, g_q;
  logic [ASID_W-1:0] a_q;
  logic [VPN_W-1:0]  pg_q;
  logic [PPN_W-1:0]  ppn_q;

  // Content after the refill, before the fence is applied.
  logic              cand_v, cand_g;
  logic [ASID_W-1:0] cand_a;
  logic [VPN_W-1:0]  cand_pg;

  always_comb begin
    cand_v  = wr_en | v_q;
    cand_g  = wr_en ? wr_glb  : g_q;
    cand_a  = wr_en ? wr_asid : a_q;
    cand_pg = wr_en ? wr_vpn  : pg_q;
  end

  assign kill_o  = fc_go && fence_match(cand_v, cand_g, cand_a, cand_pg,
                                        fc_vpn, fc_va_all, fc_asid, fc_asid_all);
  assign hit     = lookup_match(v_q, g_q, a_q, pg_q, lk_vpn, lk_asid);
  assign ppn     = ppn_q;
  assign valid_o = v_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_q   <= 1'b0;
      g_q   <= 1'b0;
      a_q   <= '0;
      pg_q  <= '0;
      ppn_q <= '0;
    end else begin
      v_q <= cand_v & ~kill_o;
      if (wr_en) begin
        g_q   <= wr_glb;
        a_q   <= wr_asid;
        pg_q  <= wr_vpn;
        ppn_q <= wr_ppn;
      end
    end
  end

endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
  import xlat_pkg::*;
#(
  parameter int unsigned ENTRIES = DEF_ENTRIES,
  parameter int unsigned VA_W    = DEF_VA_W,
  parameter int unsigned PG_OFF  = DEF_PG_OFF,
  parameter int unsigned ASID_W  = DEF_ASID_W,
  parameter int unsigned PPN_W   = DEF_PPN_W,
  localparam int unsigned VPN_W  = VA_W - PG_OFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_req,
  input  logic [VPN_W-1:0]  lk_vpn,
  input  logic [ASID_W-1:0] lk_asid,
  output logic              lk_hit,
  output logic [PPN_W-1:0]  lk_ppn,
  input  logic              fill_en,
  input  logic [VPN_W-1:0]  fill_vpn,
  input  logic [ASID_W-1:0] fill_asid,
  input  logic [PPN_W-1:0]  fill_ppn,
  input  logic              fill_glb,
  input  logic              fc_req,
  input  logic [VA_W-1:0]   fc_va,
  input  logic              fc_va_all,
  input  logic [ASID_W-1:0] fc_asid,
  input  logic              fc_asid_all,
  input  logic [1:0]        priv,
  output logic              fc_illegal
);

  // Named internal events, observed by the bound checker.
  logic               fence_ok;
  logic [ENTRIES-1:0] fill_sel;
  logic [ENTRIES-1:0] hit_vec;
  logic [ENTRIES-1:0] slot_valid;
  logic [ENTRIES-1:0] slot_kill;
  logic [PPN_W-1:0]   slot_ppn [ENTRIES];
  logic [VPN_W-1:0]   fc_vpn;
  logic [PG_OFF-1:0]  fc_offset_unused;
  logic [PPN_W-1:0]   sel_ppn;
  logic               any_hit;

  assign fence_ok         = fc_req && fence_permitted(priv_e'(priv));
  assign fc_vpn           = fc_va[VA_W-1:PG_OFF];
  assign fc_offset_unused = fc_va[PG_OFF-1:0];

  xlat_rr_ptr #(.N(ENTRIES)) u_rr (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (fill_en),
    .sel   (fill_sel)
  );

  for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
    xlat_slot #(.VPN_W(VPN_W), .ASID_W(ASID_W), .PPN_W(PPN_W)) u_slot (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en       (fill_en & fill_sel[i]),
      .wr_vpn      (fill_vpn),
      .wr_asid     (fill_asid),
      .wr_ppn      (fill_ppn),
      .wr_glb      (fill_glb),
      .fc_go       (fence_ok),
      .fc_vpn      (fc_vpn),
      .fc_va_all   (fc_va_all),
      .fc_asid     (fc_asid),
      .fc_asid_all (fc_asid_all),
      .lk_vpn      (lk_vpn),
      .lk_asid     (lk_asid),
      .hit         (hit_vec[i]),
      .ppn         (slot_ppn[i]),
      .valid_o     (slot_valid[i]),
      .kill_o      (slot_kill[i])
    );
  end

  // Lowest-numbered hitting slot wins (at most one hits in normal use).
  always_comb begin
    sel_ppn = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (hit_vec[i]) sel_ppn = slot_ppn[i];
    end
  end

  assign any_hit = lk_req && (|hit_vec);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lk_hit     <= 1'b0;
      lk_ppn     <= '0;
      fc_illegal <= 1'b0;
    end else begin
      lk_hit     <= any_hit;
      lk_ppn     <= any_hit ? sel_ppn : '0;
      fc_illegal <= fc_req && !fence_permitted(priv_e'(priv));
    end
  end

endmodule

// File: rtl/xlat_cache_chk.sv
module xlat_cache_chk #(
  parameter int unsigned ENTRIES = 8,
  parameter int unsigned PPN_W   = 20
) (
  input logic               clk,
  input logic               rst_n,
  input logic               fc_req,
  input logic [1:0]         priv,
  input logic               fc_va_all,
  input logic               fc_asid_all,
  input logic               fill_en,
  input logic               lk_req,
  input logic               lk_hit,
  input logic [PPN_W-1:0]   lk_ppn,
  input logic               fc_illegal,
  input logic [ENTRIES-1:0] slot_valid,
  input logic [ENTRIES-1:0] slot_kill,
  input logic [ENTRIES-1:0] hit_vec
);

  logic lvl_ok;
  assign lvl_ok = (priv == 2'b01) || (priv == 2'b11);

  // R8
  fault_on_low_priv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fc_req && !lvl_ok) |=> fc_illegal);

  // R8
  no_change_on_low_priv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fc_req && !lvl_ok && !fill_en) |=> $stable(slot_valid));

  // R8
  no_fault_when_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fc_req || lvl_ok) |=> !fc_illegal);

  // R4
  full_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fc_req && lvl_ok && fc_va_all && fc_asid_all) |=> (slot_valid == '0));

  // R2
  single_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

  // R2
  idle_no_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_req |=> (!lk_hit && (lk_ppn == '0)));

  // R3
  fill_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_en && !fc_req) |=> (slot_valid != '0));

  // R9 R10
  killed_gone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_kill != '0) |=> ((slot_valid & $past(slot_kill)) == '0));

endmodule

bind xlat_cache xlat_cache_chk #(.ENTRIES(ENTRIES), .PPN_W(PPN_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .fc_req      (fc_req),
  .priv        (priv),
  .fc_va_all   (fc_va_all),
  .fc_asid_all (fc_asid_all),
  .fill_en     (fill_en),
  .lk_req      (lk_req),
  .lk_hit      (lk_hit),
  .lk_ppn      (lk_ppn),
  .fc_illegal  (fc_illegal),
  .slot_valid  (slot_valid),
  .slot_kill   (slot_kill),
  .hit_vec     (hit_vec)
);

// File: tb/sim_xlat_cache.sv
module sim_xlat_cache;
  localparam int CLK_PERIOD = 10;
  localparam int VA_W = 39, PG_OFF = 12, VPN_W = 27, ASID_W = 9, PPN_W = 20;
  localparam int ROW_W = 2 + VPN_W + ASID_W + PPN_W + 1;
  localparam int NROWS = 15;

  // Row: {op(0 fill,1 lookup), vpn, asid, ppn, glb-or-expected-hit}
  localparam logic [ROW_W-1:0] TBL [NROWS] = '{
    {2'd0, 27'h100, 9'd1, 20'hA0, 1'b0},
    {2'd0, 27'h101, 9'd1, 20'hA1, 1'b0},
    {2'd0, 27'h102, 9'd2, 20'hA2, 1'b0},
    {2'd0, 27'h103, 9'd2, 20'hA3, 1'b1},
    {2'd0, 27'h104, 9'd3, 20'hA4, 1'b0},
    {2'd0, 27'h105, 9'd3, 20'hA5, 1'b1},
    {2'd0, 27'h100, 9'd2, 20'hA6, 1'b0},
    {2'd0, 27'h107, 9'd1, 20'hA7, 1'b0},
    {2'd1, 27'h100, 9'd1, 20'hA0, 1'b1},
    {2'd1, 27'h100, 9'd2, 20'hA6, 1'b1},
    {2'd1, 27'h100, 9'd3, 20'h00, 1'b0},
    {2'd1, 27'h103, 9'd7, 20'hA3, 1'b1},
    {2'd1, 27'h105, 9'd0, 20'hA5, 1'b1},
    {2'd1, 27'h102, 9'd1, 20'h00, 1'b0},
    {2'd1, 27'h1FF, 9'd1, 20'h00, 1'b0}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic lk_req = 0, fill_en = 0, fill_glb = 0, fc_req = 0, fc_va_all = 0, fc_asid_all = 0;
  logic [VPN_W-1:0] lk_vpn = '0, fill_vpn = '0;
  logic [ASID_W-1:0] lk_asid = '0, fill_asid = '0, fc_asid = '0;
  logic [PPN_W-1:0] fill_ppn = '0;
  logic [VA_W-1:0] fc_va = '0;
  logic [1:0] priv = 2'b01;
  logic lk_hit, fc_illegal;
  logic [PPN_W-1:0] lk_ppn;

  int total = 0, bad = 0, cycles = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xlat_cache u0 (
    .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .lk_vpn(lk_vpn), .lk_asid(lk_asid),
    .lk_hit(lk_hit), .lk_ppn(lk_ppn), .fill_en(fill_en), .fill_vpn(fill_vpn),
    .fill_asid(fill_asid), .fill_ppn(fill_ppn), .fill_glb(fill_glb), .fc_req(fc_req),
    .fc_va(fc_va), .fc_va_all(fc_va_all), .fc_asid(fc_asid), .fc_asid_all(fc_asid_all),
    .priv(priv), .fc_illegal(fc_illegal)
  );

  task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic fill(input logic [VPN_W-1:0] v, input logic [ASID_W-1:0] a,
                      input logic [PPN_W-1:0] p, input logic g);
    fill_en = 1; fill_vpn = v; fill_asid = a; fill_ppn = p; fill_glb = g;
    @(negedge clk);
    fill_en = 0;
  endtask

  task automatic look(input logic [VPN_W-1:0] v, input logic [ASID_W-1:0] a,
                      input logic eh, input logic [PPN_W-1:0] ep, input string rq);
    lk_req = 1; lk_vpn = v; lk_asid = a;
    @(negedge clk);
    lk_req = 0;
    check({rq, " hit"}, 32'(lk_hit), 32'(eh));
    check({rq, " ppn"}, 32'(lk_ppn), eh ? 32'(ep) : 32'h0);
  endtask

  task automatic set_fence(input logic [VPN_W-1:0] pg, input logic [PG_OFF-1:0] off,
                           input logic va_all, input logic [ASID_W-1:0] a,
                           input logic a_all, input logic [1:0] pv);
    fc_req = 1; fc_va = {pg, off}; fc_va_all = va_all; fc_asid = a;
    fc_asid_all = a_all; priv = pv;
  endtask

  task automatic fence(input logic [VPN_W-1:0] pg, input logic [PG_OFF-1:0] off,
                       input logic va_all, input logic [ASID_W-1:0] a, input logic a_all,
                       input logic [1:0] pv, input logic ill, input string rq);
    set_fence(pg, off, va_all, a, a_all, pv);
    @(negedge clk);
    fc_req = 0;
    check({rq, " fault"}, 32'(fc_illegal), 32'(ill));
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected<=100000 cycles", cycles);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 hit", 32'(lk_hit), 0);
    check("R1 ppn", 32'(lk_ppn), 0);
    check("R1 fault", 32'(fc_illegal), 0);
    look(27'h0, 9'd0, 0, 0, "R1 empty");

    // R2 table: fill eight slots then probe them
    for (int i = 0; i < NROWS; i++) begin
      logic [ROW_W-1:0] r;
      r = TBL[i];
      if (r[ROW_W-1 -: 2] == 2'd0)
        fill(r[ROW_W-3 -: VPN_W], r[PPN_W+ASID_W -: ASID_W], r[PPN_W:1], r[0]);
      else
        look(r[ROW_W-3 -: VPN_W], r[PPN_W+ASID_W -: ASID_W], r[0], r[PPN_W:1], "R2 table");
    end

    // R3 ninth refill displaces slot 0 only
    fill(27'h200, 9'd1, 20'hB0, 0);
    look(27'h100, 9'd1, 0, 0, "R3 displaced");
    look(27'h200, 9'd1, 1, 20'hB0, "R3 new");
    look(27'h101, 9'd1, 1, 20'hA1, "R3 kept");

    // R8 user and reserved mode fences fault and change nothing
    fence(27'h0, 12'h0, 1, 9'd0, 1, 2'b00, 1, "R8 user");
    look(27'h101, 9'd1, 1, 20'hA1, "R8 intact");
    fence(27'h0, 12'h0, 1, 9'd0, 1, 2'b10, 1, "R8 reserved");
    look(27'h103, 9'd2, 1, 20'hA3, "R8 intact2");
    @(negedge clk);
    check("R8 pulse ends", 32'(fc_illegal), 0);

    // R6 by ASID: globals survive; R9 lookup right after the fence
    fence(27'h0, 12'h0, 1, 9'd2, 0, 2'b01, 0, "R8 supervisor");
    look(27'h102, 9'd2, 0, 0, "R9 R6 removed");
    look(27'h103, 9'd2, 1, 20'hA3, "R6 global kept");
    look(27'h100, 9'd2, 0, 0, "R6 removed2");
    look(27'h101, 9'd1, 1, 20'hA1, "R6 other asid");

    // R5 by VA only, offset bits ignored, global removed
    fence(27'h105, 12'hABC, 0, 9'd0, 1, 2'b11, 0, "R8 machine");
    look(27'h105, 9'd3, 0, 0, "R5 removed");
    look(27'h104, 9'd3, 1, 20'hA4, "R5 neighbour");

    // R7 VA and ASID both needed; global spared
    fence(27'h107, 12'h005, 0, 9'd3, 0, 2'b01, 0, "R7 f1");
    look(27'h107, 9'd1, 1, 20'hA7, "R7 asid mismatch kept");
    fence(27'h107, 12'h000, 0, 9'd1, 0, 2'b01, 0, "R7 f2");
    look(27'h107, 9'd1, 0, 0, "R7 removed");
    fence(27'h103, 12'h000, 0, 9'd2, 0, 2'b01, 0, "R7 f3");
    look(27'h103, 9'd2, 1, 20'hA3, "R7 global kept");

    // R10 refill and fence together
    set_fence(27'h0, 12'h0, 1, 9'd4, 0, 2'b01);
    fill(27'h300, 9'd4, 20'hC0, 0);
    fc_req = 0;
    look(27'h300, 9'd4, 0, 0, "R10 matched refill gone");
    set_fence(27'h0, 12'h0, 1, 9'd4, 0, 2'b01);
    fill(27'h301, 9'd5, 20'hC1, 0);
    fc_req = 0;
    look(27'h301, 9'd5, 1, 20'hC1, "R10 unmatched refill stays");

    // R4 all/all removes everything, globals too
    fence(27'h0, 12'h0, 1, 9'd0, 1, 2'b01, 0, "R4");
    look(27'h103, 9'd2, 0, 0, "R4 global gone");
    look(27'h104, 9'd3, 0, 0, "R4 gone");
    look(27'h200, 9'd1, 0, 0, "R4 gone2");
    look(27'h301, 9'd5, 0, 0, "R4 gone3");

    done = 1;
    finish_run();
  end
endmodule